// File: doc/BRIEF.md
# Shared-Half-Sum Carry Select Adder

This block is a purely combinational binary adder of parameterised width (64 bits by default). It takes two unsigned operands and a carry input, and it returns the sum together with the carry out of the top bit. It holds no state, so its outputs follow its inputs within the same cycle. A surrounding datapath places it between its own registers.

The adder does not build two complete ripple adders. It forms the per-bit propagate (XOR) and generate (AND) terms once, and it shares them. Two carry chains run side by side over those shared terms. One chain assumes the incoming carry is zero. The other assumes the incoming carry is one, and it differs only at bit 0. The real carry input then picks a carry for each bit through a single AND-OR gate. No multiplexer is used, because the carry of the assume-one chain is always at least the carry of the assume-zero chain. A final row of XOR gates joins each propagate bit with the selected carry from the bit below.

Top module: `csla_shared`

## Requirements
- R1: For every pair of operands and both carry-in values, the concatenation {carry-out, sum} equals a_i + b_i + cin_i, computed at N+1 bits.
- R2: Operands with no set bit in common, added with cin_i = 0, give a sum equal to their bitwise OR and a carry-out of 0.
- R3: With cin_i = 0, the selected carries are those of the chain that assumes a zero carry in, so the result is a_i + b_i.
- R4: With cin_i = 1, the selected carries are those of the chain that assumes a carry in of one, so the result is a_i + b_i + 1. An all-ones a_i plus a zero b_i therefore gives a sum of 0 and a carry-out of 1.
- R5: Each bit of the assume-one chain is set whenever the matching bit of the assume-zero chain is set. With b_i = ~a_i, cin_i = 0 gives an all-ones sum and a carry-out of 0, and cin_i = 1 gives a zero sum and a carry-out of 1.
- R6: cout_o is the carry out of the most significant bit. Adding 2^(N-1) to itself gives a sum of 0 and a carry-out of 1.
- R7: Sum bit 0 equals a_i[0] XOR b_i[0] XOR cin_i.
- R8: The block contains no storage. A change at the inputs shows at the outputs with no clock edge in between.
- R9: The width N is a parameter with N >= 2. Every requirement above holds at a width other than the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Low N bits of the sum |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The bound checker watches the internal carry chains as the inputs change. It checks that the assume-one chain always covers the assume-zero chain, and that the selected carry vector matches the chain named by the carry input. It also compares the full result with an arithmetic sum and checks the lowest sum bit. Some behaviour only the bench's scenarios can show: the full-propagate and MSB-overflow corner cases, the disjoint-operand case, the response without a clock edge, and the exhaustive sweep at a narrow width.

// File: rtl/csla_pkg.sv
package csla_pkg;

    typedef enum logic {
        CARRY_ASSUME_ZERO = 1'b0,
        CARRY_ASSUME_ONE  = 1'b1
    } carry_assume_e;

endpackage

// File: rtl/csla_halfsum.sv
module csla_halfsum #(
    parameter int N = 64
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] prop_o,
    output logic [N-1:0] gen_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign prop_o[i] = a_i[i] ^ b_i[i];
        assign gen_o[i]  = a_i[i] & b_i[i];
    end
endmodule

// File: rtl/csla_chain.sv
module csla_chain
    import csla_pkg::*;
#(
    parameter int            N      = 64,
    parameter carry_assume_e ASSUME = CARRY_ASSUME_ZERO
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-1:0] gen_i,
    output logic [N-1:0] carry_o
);
    // Bit 0 is the only place where the assumed carry-in matters.
    if (ASSUME == CARRY_ASSUME_ONE) begin : g_base_one
        assign carry_o[0] = gen_i[0] | prop_i[0];
    end else begin : g_base_zero
        assign carry_o[0] = gen_i[0];
    end

    for (genvar i = 1; i < N; i++) begin : g_ripple
        assign carry_o[i] = gen_i[i] | (prop_i[i] & carry_o[i-1]);
    end
endmodule

// File: rtl/csla_select.sv
module csla_select #(
    parameter int N = 64
) (
    input  logic [N-1:0] carry0_i,
    input  logic [N-1:0] carry1_i,
    input  logic         cin_i,
    output logic [N-1:0] carry_o
);
    // carry1 covers carry0, so AND-OR replaces a multiplexer.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign carry_o[i] = carry0_i[i] | (cin_i & carry1_i[i]);
    end
endmodule

// File: rtl/csla_sumxor.sv
module csla_sumxor #(
    parameter int N = 64
) (
    input  logic [N-1:0] prop_i,
    input  logic [N-2:0] carry_low_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o
);
    assign sum_o[0] = prop_i[0] ^ cin_i;
    for (genvar i = 1; i < N; i++) begin : g_bit
        assign sum_o[i] = prop_i[i] ^ carry_low_i[i-1];
    end
endmodule

// File: rtl/csla_shared.sv
module csla_shared
    import csla_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    localparam int MSB = N - 1;

    logic [N-1:0] prop_d;
    logic [N-1:0] gen_d;
    logic [N-1:0] carry0_d;
    logic [N-1:0] carry1_d;
    logic [N-1:0] csel_d;

    csla_halfsum #(.N(N)) u_halfsum (
        .a_i   (a_i),
        .b_i   (b_i),
        .prop_o(prop_d),
        .gen_o (gen_d)
    );

    csla_chain #(.N(N), .ASSUME(CARRY_ASSUME_ZERO)) u_chain0 (
        .prop_i (prop_d),
        .gen_i  (gen_d),
        .carry_o(carry0_d)
    );

    csla_chain #(.N(N), .ASSUME(CARRY_ASSUME_ONE)) u_chain1 (
        .prop_i (prop_d),
        .gen_i  (gen_d),
        .carry_o(carry1_d)
    );

    csla_select #(.N(N)) u_select (
        .carry0_i(carry0_d),
        .carry1_i(carry1_d),
        .cin_i   (cin_i),
        .carry_o (csel_d)
    );

    csla_sumxor #(.N(N)) u_sumxor (
        .prop_i     (prop_d),
        .carry_low_i(csel_d[MSB-1:0]),
        .cin_i      (cin_i),
        .sum_o      (sum_o)
    );

    assign cout_o = csel_d[MSB];
endmodule

// File: rtl/csla_shared_chk.sv
module csla_shared_chk #(
    parameter int N = 64
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o,
    input logic [N-1:0] carry0_d,
    input logic [N-1:0] carry1_d,
    input logic [N-1:0] csel_d
);
    logic [N:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

    always_comb begin
        // R1, R6: full result against arithmetic
        a_r1_total_matches: assert ({cout_o, sum_o} == ref_total);
        // R3: zero carry-in follows the assume-zero chain
        a_r3_cin0_picks_chain0: assert (cin_i || (csel_d == carry0_d));
        // R4: carry-in of one follows the assume-one chain
        a_r4_cin1_picks_chain1: assert (!cin_i || (csel_d == carry1_d));
        // R5: assume-one chain covers assume-zero chain
        a_r5_chain1_covers_chain0: assert ((carry0_d & ~carry1_d) == '0);
        // R7: lowest sum bit
        a_r7_sum_bit0: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i));
    end
endmodule

bind csla_shared csla_shared_chk #(.N(N)) i_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .carry0_d(carry0_d),
    .carry1_d(carry1_d),
    .csel_d  (csel_d)
);

// File: tb/test_csla_shared.sv
module test_csla_shared;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 64;
    localparam int WS = 5;
    localparam int NVEC = 10;
    localparam int NRAND = 600;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
    } vec_t;

    // R1, R3, R4 vector table: expected values computed in the loop
    localparam vec_t VEC [NVEC] = '{
        '{64'h0, 64'h0, 1'b0},
        '{64'h0, 64'h0, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},
        '{64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1},
        '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
        '{64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1}
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]  a = '0, b = '0;
    logic          cin = 1'b0;
    logic [W-1:0]  sum;
    logic          cout;
    logic [WS-1:0] as = '0, bs = '0;
    logic          cins = 1'b0;
    logic [WS-1:0] sums;
    logic          couts;

    int compared = 0;
    int mismatched = 0;

    csla_shared #(.N(W)) i_csla_shared (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    csla_shared #(.N(WS)) i_csla_shared_n5 (
        .a_i(as), .b_i(bs), .cin_i(cins), .sum_o(sums), .cout_o(couts)
    );

    task automatic check_wide(input string req, input logic [W:0] exp);
        compared++;
        if ({cout, sum} !== exp) begin
            mismatched++;
            $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h",
                     req, a, b, cin, {cout, sum}, exp);
        end
    endtask

    task automatic apply_wide(input logic [W-1:0] ta, input logic [W-1:0] tb,
                              input logic tc);
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        #2;
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] ta,
                                           input logic [W-1:0] tb,
                                           input logic tc);
        return {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // Idle state: zero inputs give zero outputs (R1)
        #2;
        check_wide("R1 idle", '0);

        // Table walk (R1, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            apply_wide(VEC[i].a, VEC[i].b, VEC[i].cin);
            check_wide(VEC[i].cin ? "R4 table" : "R3 table",
                       ref_add(VEC[i].a, VEC[i].b, VEC[i].cin));
        end

        // R2: disjoint operands give OR, no carry
        apply_wide(64'hF0F0_1234_0000_8001, 64'h0F0F_0000_ABCD_0110, 1'b0);
        check_wide("R2 disjoint", {1'b0, 64'hF0F0_1234_0000_8001 | 64'h0F0F_0000_ABCD_0110});

        // R4: all ones plus zero with carry in
        apply_wide('1, '0, 1'b1);
        check_wide("R4 all-ones+cin", {1'b1, {W{1'b0}}});

        // R5: full propagate, both carry-in values
        apply_wide(64'h3C3C_9876_0F0F_A5A5, ~64'h3C3C_9876_0F0F_A5A5, 1'b0);
        check_wide("R5 propagate cin0", {1'b0, {W{1'b1}}});
        apply_wide(64'h3C3C_9876_0F0F_A5A5, ~64'h3C3C_9876_0F0F_A5A5, 1'b1);
        check_wide("R5 propagate cin1", {1'b1, {W{1'b0}}});

        // R6: MSB overflow
        apply_wide({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
        check_wide("R6 msb carry", {1'b1, {W{1'b0}}});

        // R7: bit 0 from carry-in alone
        apply_wide(64'h2, 64'h4, 1'b1);
        check_wide("R7 bit0", {1'b0, 64'h7});

        // R8: input changes twice with no clock edge between samples
        @(posedge clk);
        #1;
        a = 64'h1111; b = 64'h2222; cin = 1'b1;
        #1;
        check_wide("R8 no edge first", ref_add(64'h1111, 64'h2222, 1'b1));
        a = 64'hFFFF_0000_0000_0000; b = 64'h0001_0000_0000_0000; cin = 1'b0;
        #1;
        check_wide("R8 no edge second", ref_add(64'hFFFF_0000_0000_0000, 64'h0001_0000_0000_0000, 1'b0));

        // R1: random pairs
        for (int i = 0; i < NRAND; i++) begin
            logic [W-1:0] ra, rb;
            logic rc;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rc = 1'($urandom);
            apply_wide(ra, rb, rc);
            check_wide("R1 random", ref_add(ra, rb, rc));
        end

        // R9: exhaustive sweep at a narrow width
        for (int ia = 0; ia < (1 << WS); ia++) begin
            for (int ib = 0; ib < (1 << WS); ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    logic [WS:0] exp;
                    as = WS'(ia); bs = WS'(ib); cins = 1'(ic);
                    exp = {1'b0, WS'(ia)} + {1'b0, WS'(ib)} + {{WS{1'b0}}, 1'(ic)};
                    #1;
                    compared++;
                    if ({couts, sums} !== exp) begin
                        mismatched++;
                        $display("FAIL R9 a=%h b=%h cin=%0d actual=%h expected=%h",
                                 as, bs, ic, {couts, sums}, exp);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule